// File: doc/BRIEF.md
# DMX Slot Window Change Detector

The block sits behind a DMX receiver and watches the stream of decoded slots. Each beat on the input stream is a start-of-frame marker, a slot beat that carries a slot index and its 8-bit value, or a frame-complete marker. A programmable window, given by a 16-bit first slot and a 16-bit slot count, selects the slots of interest. The block keeps a copy of every in-window slot it has accepted. At each frame-complete marker it pulses a frame event. If any in-window slot received during that frame held a value different from the stored copy, it pulses a change event in the same cycle.

Both events are also held in pending flags. A read request clears the flags and streams the stored window out, lowest slot first, on a valid/ready output. The input stream follows valid/ready rules as well. `in_ready` is low while a readout is running and in the cycle a read request is taken, because the slot store has a single read port shared by the comparison and the readout. The sender must hold its beat until `in_ready` is high. The receiver of the output may hold `out_ready` low for any number of cycles, and the output beat stays unchanged until it is taken.

Top module: `dmxw_change_detect`

## Requirements
- R1: After reset the window covers slots 0 to 511 (count 512, first slot 0), `rx_pend`, `chg_pend`, `frame_evt`, `chg_evt` and `out_valid` are 0, and `in_ready` is 1.
- R2: One cycle after a frame-complete beat is accepted, `frame_evt` is high for exactly one cycle and `rx_pend` becomes 1.
- R3: `chg_evt` pulses together with `frame_evt` when at least one in-window slot accepted since the last start-of-frame marker had a value different from the stored one. A start-of-frame marker discards the changes seen so far, but the values already stored are kept.
- R4: A slot is in the window when its index is at least the first slot and below first slot plus count, with the end clipped at 512. A slot outside the window is neither compared nor stored.
- R5: The first frame-complete beat after reset, and the first one after a window write (`cfg_wr`), reports a change.
- R6: In a frame that ends early, only the slots received are compared, and slots not received keep their stored values.
- R7: A read request (`rd_start` while no readout runs) clears `rx_pend` and `chg_pend` on the next cycle. It then streams each in-window stored value in ascending slot order, with `out_last` set on the final beat.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `in_ready` is low for the whole readout.
- R9: A read request for an empty window (count 0, or first slot 512 or above) produces no output beat.
- R10: `in_kind` is encoded as 0 = start of frame, 1 = slot, and 2 = frame complete. Code 3 is accepted but has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load the window registers |
| cfg_start | input | 16 | First slot of the window |
| cfg_len | input | 16 | Number of slots in the window |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_kind | input | 2 | Beat kind (R10 encoding) |
| in_index | input | 16 | Slot index of a slot beat |
| in_value | input | 8 | Slot value of a slot beat |
| rd_start | input | 1 | Request a readout of the window |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat can be taken |
| out_data | output | 8 | Stored slot value |
| out_last | output | 1 | Final beat of the readout |
| frame_evt | output | 1 | Frame-complete pulse |
| chg_evt | output | 1 | Window-changed pulse |
| rx_pend | output | 1 | Frame seen since last readout |
| chg_pend | output | 1 | Change seen since last readout |

## Verification
Single-slot frames are sent with unchanged values, changed values, slots one below and one past each window edge, and a repeated write of the same value. Together they separate a correct in-window compare from off-by-one bounds and from a detector that fires on every slot. Stored contents are then read back, which shows whether out-of-window slots were stored and whether slots left out of short frames kept their values. Directed cases cover these:
- a window clipped at slot 511;
- an empty window;
- a marker of code 3;
- a frame restarted by a second start marker;
- a readout held by back-pressure.

// File: rtl/dmxw_pkg.sv
package dmxw_pkg;
  typedef enum logic [1:0] {
    K_SOF  = 2'd0,
    K_SLOT = 2'd1,
    K_EOF  = 2'd2,
    K_NONE = 2'd3
  } beat_kind_e;
endpackage

// File: rtl/dmxw_window.sv
module dmxw_window #(
  parameter int SLOTS     = 512,
  parameter int IDX_W     = 16,
  parameter int RESET_LEN = 512,
  parameter int HI_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_start,
  input  logic [IDX_W-1:0] cfg_len,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_hit,
  output logic [IDX_W-1:0] win_lo,
  output logic [HI_W-1:0]  win_hi,
  output logic             win_nonempty
);
  logic [IDX_W-1:0] len_q;
  logic [IDX_W:0]   sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo <= '0;
      len_q  <= IDX_W'(RESET_LEN);
    end else if (cfg_wr) begin
      win_lo <= cfg_start;
      len_q  <= cfg_len;
    end
  end

  // exclusive end, clipped to the frame size
  always_comb begin
    sum = {1'b0, win_lo} + {1'b0, len_q};
    if (sum > (IDX_W+1)'(SLOTS)) win_hi = HI_W'(SLOTS);
    else                         win_hi = HI_W'(sum);
  end

  assign probe_hit    = (probe_idx >= win_lo) && (probe_idx < IDX_W'(win_hi));
  assign win_nonempty = IDX_W'(win_hi) > win_lo;

  // R4: a hit never lies at or beyond the frame size
  p_hit_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> (probe_idx < IDX_W'(SLOTS)));
endmodule

// File: rtl/dmxw_store.sv
module dmxw_store #(
  parameter int SLOTS = 512,
  parameter int AW    = 9,
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [VAL_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [VAL_W-1:0] rdata
);
  logic [VAL_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmxw_reader.sv
module dmxw_reader #(
  parameter int AW   = 9,
  parameter int HI_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic [AW-1:0]   lo,
  input  logic [HI_W-1:0] hi,
  input  logic            nonempty,
  input  logic            out_ready,
  output logic            busy,
  output logic            accept,
  output logic [AW-1:0]   ptr,
  output logic            last
);
  logic [AW-1:0] end_q;

  assign accept = start_req && !busy;
  assign last   = busy && (ptr == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr   <= '0;
      end_q <= '0;
    end else if (accept) begin
      busy  <= nonempty;
      ptr   <= lo;
      end_q <= AW'(hi - 1'b1);
    end else if (busy && out_ready) begin
      if (last) busy <= 1'b0;
      else      ptr  <= ptr + 1'b1;
    end
  end

  // R7: the pointer never runs past the latched end
  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ptr <= end_q));
endmodule

// File: rtl/dmxw_change_detect.sv
module dmxw_change_detect
  import dmxw_pkg::*;
#(
  parameter int SLOTS     = 512,
  parameter int IDX_W     = 16,
  parameter int VAL_W     = 8,
  parameter int RESET_LEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_start,
  input  logic [IDX_W-1:0] cfg_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [IDX_W-1:0] in_index,
  input  logic [VAL_W-1:0] in_value,
  input  logic             rd_start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VAL_W-1:0] out_data,
  output logic             out_last,
  output logic             frame_evt,
  output logic             chg_evt,
  output logic             rx_pend,
  output logic             chg_pend
);
  localparam int AW   = $clog2(SLOTS);
  localparam int HI_W = $clog2(SLOTS + 1);

  beat_kind_e       kind;
  logic             beat, is_sof, is_slot, is_eof;
  logic             hit, store_we, differs;
  logic [IDX_W-1:0] win_lo;
  logic [HI_W-1:0]  win_hi;
  logic             win_nonempty;
  logic             rd_busy, rd_accept;
  logic [AW-1:0]    rd_ptr, raddr;
  logic [VAL_W-1:0] rdata;
  logic             sticky_q, first_q;

  assign kind    = beat_kind_e'(in_kind);
  assign beat    = in_valid && in_ready;
  assign is_sof  = beat && (kind == K_SOF);
  assign is_slot = beat && (kind == K_SLOT);
  assign is_eof  = beat && (kind == K_EOF);

  // single read port: readout owns it while busy, so input stalls
  assign in_ready = !rd_busy && !rd_start;

  dmxw_window #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .RESET_LEN(RESET_LEN), .HI_W(HI_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
    .cfg_len(cfg_len), .probe_idx(in_index), .probe_hit(hit),
    .win_lo(win_lo), .win_hi(win_hi), .win_nonempty(win_nonempty)
  );

  assign store_we = is_slot && hit;
  assign raddr    = rd_busy ? rd_ptr : in_index[AW-1:0];

  dmxw_store #(.SLOTS(SLOTS), .AW(AW), .VAL_W(VAL_W)) u_store (
    .clk(clk), .we(store_we), .waddr(in_index[AW-1:0]), .wdata(in_value),
    .raddr(raddr), .rdata(rdata)
  );

  assign differs = rdata != in_value;

  dmxw_reader #(.AW(AW), .HI_W(HI_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .start_req(rd_start), .lo(win_lo[AW-1:0]),
    .hi(win_hi), .nonempty(win_nonempty), .out_ready(out_ready),
    .busy(rd_busy), .accept(rd_accept), .ptr(rd_ptr), .last(out_last)
  );

  assign out_valid = rd_busy;
  assign out_data  = rdata;

  // change accumulation within a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      first_q  <= 1'b1;
    end else begin
      if (cfg_wr || is_sof || is_eof) sticky_q <= 1'b0;
      else if (store_we && differs)   sticky_q <= 1'b1;
      if (cfg_wr)      first_q <= 1'b1;
      else if (is_eof) first_q <= 1'b0;
    end
  end

  // events and pending flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_evt <= 1'b0;
      chg_evt   <= 1'b0;
      rx_pend   <= 1'b0;
      chg_pend  <= 1'b0;
    end else begin
      frame_evt <= is_eof;
      chg_evt   <= is_eof && (sticky_q || first_q);
      if (rd_accept) begin
        rx_pend  <= 1'b0;
        chg_pend <= 1'b0;
      end else if (is_eof) begin
        rx_pend  <= 1'b1;
        if (sticky_q || first_q) chg_pend <= 1'b1;
      end
    end
  end

  p_frame_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_eof |=> (frame_evt && rx_pend));
  p_chg_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> frame_evt);
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (!rx_pend && !chg_pend));
  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  p_no_input_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/dmxw_change_detect_test.sv
module dmxw_change_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_start = '0, cfg_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = '0;
  logic [15:0] in_index = '0;
  logic [7:0]  in_value = '0;
  logic        rd_start = 1'b0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        frame_evt, chg_evt, rx_pend, chg_pend;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmxw_change_detect uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
    .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_index(in_index), .in_value(in_value),
    .rd_start(rd_start), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .frame_evt(frame_evt),
    .chg_evt(chg_evt), .rx_pend(rx_pend), .chg_pend(chg_pend)
  );

  // {index, value, expected change}
  localparam logic [24:0] VEC [10] = '{
    {16'd10, 8'd0, 1'b0}, {16'd10, 8'd5, 1'b1}, {16'd10, 8'd5, 1'b0},
    {16'd13, 8'd9, 1'b1}, {16'd14, 8'd9, 1'b0}, {16'd9,  8'd7, 1'b0},
    {16'd13, 8'd9, 1'b0}, {16'd11, 8'd0, 1'b0}, {16'd12, 8'd1, 1'b1},
    {16'd12, 8'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic [15:0] idx, input logic [7:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_index = idx; in_value = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_frame(input bit exp_chg, input string req);
    put(2'd2, 16'd0, 8'd0);
    check(frame_evt == 1'b1, req, frame_evt, 1);
    check(chg_evt == exp_chg, req, chg_evt, exp_chg);
  endtask

  task automatic set_window(input logic [15:0] s, input logic [15:0] l);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_start = s; cfg_len = l;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_window(input int n, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input logic [7:0] e3, input string req);
    logic [7:0] ev [4];
    int k;
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    k = 0;
    @(negedge clk);
    rd_start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    check(rx_pend == 1'b0 && chg_pend == 1'b0, "R7 pend cleared", rx_pend, 0);
    for (int g = 0; g < n + 5; g++) begin
      if (out_valid) begin
        if (k < 4) check(out_data == ev[k], req, out_data, ev[k]);
        check(out_last == (k == n - 1), "R7 last flag", out_last, k == n - 1);
        k++;
        if (out_last) break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check(k == n, req, k, n);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 readout ended", out_valid, 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset ready", in_ready, 1);
    check(rx_pend == 1'b0 && chg_pend == 1'b0, "R1 reset pend", rx_pend, 0);
    check(frame_evt == 1'b0 && chg_evt == 1'b0, "R1 reset events", frame_evt, 0);
    rst_n = 1'b1;

    // R1 default window reaches slot 511; R5 first frame is a change
    put(2'd0, 16'd0, 8'd0);
    put(2'd1, 16'd511, 8'd4);
    finish_frame(1'b1, "R5 first frame after reset");
    check(rx_pend == 1'b1 && chg_pend == 1'b1, "R2 pend set", rx_pend, 1);
    @(negedge clk);
    check(frame_evt == 1'b0, "R2 single pulse", frame_evt, 0);
    put(2'd0, 16'd0, 8'd0);
    put(2'd1, 16'd511, 8'd5);
    finish_frame(1'b1, "R1 default window covers 511");

    // window 10..13, primed
    set_window(16'd10, 16'd4);
    put(2'd0, 16'd0, 8'd0);
    for (int s = 10; s < 14; s++) put(2'd1, 16'(s), 8'd0);
    finish_frame(1'b1, "R5 first frame after window write");
    put(2'd0, 16'd0, 8'd0);
    for (int s = 10; s < 14; s++) put(2'd1, 16'(s), 8'd0);
    finish_frame(1'b0, "R3 identical frame");

    // table: single-slot short frames (R3 R4 R6)
    foreach (VEC[i]) begin
      put(2'd0, 16'd0, 8'd0);
      put(2'd1, VEC[i][24:9], VEC[i][8:1]);
      finish_frame(VEC[i][0], "R3 R4 R6 vector");
    end
    read_window(4, 8'd5, 8'd0, 8'd1, 8'd9, "R6 R7 stored window");

    // R8 back-pressure
    @(negedge clk);
    rd_start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    rd_start = 1'b0;
    for (int h = 0; h < 3; h++) begin
      check(out_valid == 1'b1 && out_data == 8'd5, "R8 held beat", out_data, 5);
      check(in_ready == 1'b0, "R8 input stalled", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int g = 0; g < 10; g++) begin
      if (out_valid && out_last) break;
      @(negedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R8 drained", out_valid, 0);

    // R10 code 3 has no effect
    put(2'd3, 16'd10, 8'd77);
    check(frame_evt == 1'b0, "R10 code 3 no event", frame_evt, 0);
    put(2'd0, 16'd0, 8'd0);
    finish_frame(1'b0, "R10 empty frame no change");

    // R3 restart marker discards accumulated change
    put(2'd0, 16'd0, 8'd0);
    put(2'd1, 16'd10, 8'd99);
    put(2'd0, 16'd0, 8'd0);
    finish_frame(1'b0, "R3 restart discards change");
    read_window(4, 8'd99, 8'd0, 8'd1, 8'd9, "R10 R3 contents after restart");

    // R4 clip at 512
    set_window(16'd510, 16'd10);
    put(2'd0, 16'd0, 8'd0);
    put(2'd1, 16'd510, 8'd1);
    put(2'd1, 16'd511, 8'd2);
    put(2'd1, 16'd512, 8'd3);
    finish_frame(1'b1, "R4 clipped window frame");
    read_window(2, 8'd1, 8'd2, 8'd0, 8'd0, "R4 clipped readout");

    // R9 empty window
    set_window(16'd600, 16'd5);
    read_window(0, 8'd0, 8'd0, 8'd0, 8'd0, "R9 empty window");
    set_window(16'd10, 16'd0);
    read_window(0, 8'd0, 8'd0, 8'd0, 8'd0, "R9 zero count");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule